// File: doc/BRIEF.md
# Sync Edge Detector with Presettable Clock-State Counter

This block lines up the internal clock phase of several chips that share one periodic alignment signal. The alignment input arrives with no known timing relation to the local system clock. It first passes through a synchronizer of two flip-flops, the same on every chip. A programmable digital delay of 0 to 7 system-clock cycles follows. An edge detector then produces a strobe one cycle wide for each low-to-high transition it sees.

The strobe forces a free-running clock-state counter to a fixed value. On the next cycle the counter continues to count up at the system clock rate and wraps at its modulus. The counter value is exported, so that logic around the block can decode divided internal clocks from it. Chips fed with edge-aligned alignment inputs, and programmed with matching delay words, end up with identical counter values on the same system-clock edges.

Top module: `syncPhaseAlign`

## Requirements
- R1: With a delay word of 0, a rising edge on `syncIn` set up before system-clock edge k makes `syncPulse` high during the cycle after edge k+2. This is the fixed latency of the two-stage synchronizer plus the edge register.
- R2: `syncPulse` is never high for two consecutive cycles; each detected edge gives exactly one cycle of pulse.
- R3: A periodic `syncIn` gives exactly one pulse per input period, so the pulse rate equals the input frequency.
- R4: In the cycle after `syncPulse` is high, `clkState` equals the parameter PRESET. The default value of PRESET is 0.
- R5: In every cycle with no preset, `clkState` goes up by one, and it goes from CNT_MOD-1 to 0. The default value of CNT_MOD is 16.
- R6: `clkState` is 0 after reset, stays below CNT_MOD at all times, and `syncPulse` is 0 after reset.
- R7: A delay word of d (an unsigned number of 0 to 7 on `delayWord`) delays the pulse, and the preset that follows it, by exactly d cycles compared with a delay word of 0.
- R8: Only a 0-to-1 transition of `syncIn` gives a pulse. While the input stays high, and on its falling edge, no pulse appears and the counter keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | Periodic alignment input, asynchronous to `clk` |
| delayWord | input | DLY_W (3) | Added delay, in system-clock cycles, applied before edge detection |
| syncPulse | output | 1 | Strobe one cycle wide for each detected rising edge |
| clkState | output | $clog2(CNT_MOD) (4) | Clock-state counter value, from which derived clocks are decoded |

## Verification
The embedded assertions check on every cycle that the pulse lasts a single cycle, that a preset lands on PRESET, that the counter steps by one and wraps correctly, and that it stays in range. They also check that an input held high gives no pulse, and the zero-delay latency. The exact latency for each of the eight delay words, the one-pulse-per-period rate under a repeated input, and the counting sequence through several wraps after a preset can only be shown by the bench scenarios. The bench uses a modulus of 12 and a preset of 5, so that a wrap to zero and a preset to a non-zero value are easy to tell apart.

// File: rtl/syncPhaseAlign_pkg.sv
package syncPhaseAlign_pkg;
  // Strobes from the edge-detect control into the counter datapath
  typedef struct packed {
    logic preset;
  } ctrlStrobeT;
endpackage

// File: rtl/syncEdgeCtrl.sv
module syncEdgeCtrl
  import syncPhaseAlign_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic [DLY_W-1:0] delayWord,
  output ctrlStrobeT       strobe
);
  localparam int MAX_DLY = (1 << DLY_W) - 1;

  // Metastability synchronizer
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   synced;

  always_ff @(posedge clk) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], syncIn};
  end
  assign synced = syncChain[SYNC_STAGES-1];

  // Programmable delay line: tap i is the synced input delayed i cycles
  logic [MAX_DLY-1:0] dlyReg;
  logic [MAX_DLY:0]   tap;

  always_ff @(posedge clk) begin
    if (!rstN) dlyReg <= '0;
    else       dlyReg <= {dlyReg[MAX_DLY-2:0], synced};
  end

  generate
    for (genvar i = 0; i <= MAX_DLY; i++) begin : gTap
      if (i == 0) begin : gDirect
        assign tap[i] = synced;
      end else begin : gDelayed
        assign tap[i] = dlyReg[i-1];
      end
    end
  endgenerate

  // Rising-edge detector
  logic selTap;
  logic prevTap;
  logic pulseReg;

  assign selTap = tap[delayWord];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevTap  <= 1'b0;
      pulseReg <= 1'b0;
    end else begin
      prevTap  <= selTap;
      pulseReg <= selTap & ~prevTap;
    end
  end

  assign strobe.preset = pulseReg;

  AST_PULSE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    pulseReg |=> !pulseReg); // R2
  AST_HELD_HIGH_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (prevTap && selTap) |=> !pulseReg); // R8
  AST_ZERO_DELAY_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (delayWord == '0 && $rose(synced)) |=> pulseReg); // R1
endmodule

// File: rtl/clkStateDp.sv
module clkStateDp
  import syncPhaseAlign_pkg::*;
#(
  parameter int CNT_MOD = 16,
  parameter int PRESET  = 0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobeT                 strobe,
  output logic [$clog2(CNT_MOD)-1:0] clkState
);
  localparam int CW = $clog2(CNT_MOD);
  localparam logic [CW-1:0] LAST    = CW'(CNT_MOD - 1);
  localparam logic [CW-1:0] LOADVAL = CW'(PRESET);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.preset) cnt <= LOADVAL;
    else if (cnt == LAST)   cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assign clkState = cnt;

  initial begin
    AST_PRESET_LEGAL: assert (PRESET < CNT_MOD); // R4
  end

  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.preset |=> (clkState == LOADVAL)); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.preset && clkState != LAST) |=> (clkState == $past(clkState) + 1'b1)); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.preset && clkState == LAST) |=> (clkState == '0)); // R5
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (int'(clkState) < CNT_MOD)); // R6
endmodule

// File: rtl/syncPhaseAlign.sv
module syncPhaseAlign
  import syncPhaseAlign_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_W       = 3,
  parameter int CNT_MOD     = 16,
  parameter int PRESET      = 0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       syncIn,
  input  logic [DLY_W-1:0]           delayWord,
  output logic                       syncPulse,
  output logic [$clog2(CNT_MOD)-1:0] clkState
);
  ctrlStrobeT strobe;

  syncEdgeCtrl #(.SYNC_STAGES(SYNC_STAGES), .DLY_W(DLY_W)) uCtrl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .delayWord(delayWord), .strobe(strobe)
  );

  clkStateDp #(.CNT_MOD(CNT_MOD), .PRESET(PRESET)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .clkState(clkState)
  );

  assign syncPulse = strobe.preset;
endmodule

// File: tb/sim_syncPhaseAlign.sv
`timescale 1ns/1ps
module sim_syncPhaseAlign;
  localparam int MOD = 12;
  localparam int PRE = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       syncIn = 1'b0;
  logic [2:0] delayWord = '0;
  logic       syncPulse;
  logic [3:0] clkState;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  syncPhaseAlign #(.CNT_MOD(MOD), .PRESET(PRE)) u0 (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .delayWord(delayWord),
    .syncPulse(syncPulse), .clkState(clkState)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int pulses;
    int exp;
    int maxRun;
    int run;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R6: reset state, sampled before the first counting edge
    chk(clkState == 0, "R6 reset state", clkState, 0);
    chk(syncPulse == 0, "R6 reset pulse", syncPulse, 0);
    // R5: free-running sweep through several wraps
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      chk(clkState == n % MOD, "R5 free run", clkState, n % MOD);
    end

    // R1 / R7 / R4 / R5 / R8: sweep every delay word
    for (int d = 0; d < 8; d++) begin
      delayWord = 3'(d);
      repeat (12) @(negedge clk);
      syncIn = 1'b1;
      repeat (2 + d) @(negedge clk);
      chk(syncPulse == 0, d == 0 ? "R1 early" : "R7 early", syncPulse, 0);
      @(negedge clk);
      chk(syncPulse == 1, d == 0 ? "R1 pulse" : "R7 pulse", syncPulse, 1);
      @(negedge clk);
      chk(syncPulse == 0, "R2 width", syncPulse, 0);
      chk(clkState == PRE, "R4 preset", clkState, PRE);
      pulses = 0;
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk);
        if (syncPulse) pulses++;
        exp = (PRE + k) % MOD;
        chk(clkState == exp, "R5 after preset", clkState, exp);
      end
      chk(pulses == 0, "R8 held high", pulses, 0);
      syncIn = 1'b0;
      pulses = 0;
      for (int k = 0; k < 14; k++) begin
        @(negedge clk);
        if (syncPulse) pulses++;
      end
      chk(pulses == 0, "R8 falling edge", pulses, 0);
    end

    // R3 / R2: periodic input, six periods of 20 cycles
    delayWord = 3'd2;
    pulses = 0;
    maxRun = 0;
    run = 0;
    for (int p = 0; p < 6; p++) begin
      for (int c = 0; c < 20; c++) begin
        syncIn = (c < 10);
        @(negedge clk);
        if (syncPulse) begin pulses++; run++; end else run = 0;
        if (run > maxRun) maxRun = run;
      end
    end
    syncIn = 1'b0;
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      if (syncPulse) begin pulses++; run++; end else run = 0;
      if (run > maxRun) maxRun = run;
    end
    chk(pulses == 6, "R3 pulse rate", pulses, 6);
    chk(maxRun == 1, "R2 max run", maxRun, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule